// File: doc/BRIEF.md
# Extended-Precision Operand Exception Checker

This block sits beside the operand fetch of a floating-point unit and examines the one or two 80-bit extended-precision source operands of each instruction. Each operand is sorted into one of seven classes: zero, normal, denormal, infinity, quiet NaN, signaling NaN, or unsupported encoding. From those classes, the operation class of the instruction and a compatibility-mode select, the block decides whether the invalid-operation and denormal-operand exceptions are raised.

Two behaviours are selected by the mode input. In modern mode, the unsupported encodings are rejected and quiet NaNs are tolerated except by compares and integer or decimal stores. The denormal check also covers transcendental and exponent-extract operations in this mode. In legacy mode, every NaN is rejected, the unsupported encodings are accepted, and denormals are passed through unnormalized.

The classes, the exception flags, a per-operand normalize request and a fault strobe are all produced in the same cycle as the valid strobe. A two-bit sticky status register collects the flags over time. The arithmetic datapath, the normalizer and trap delivery belong elsewhere.

Top module: `fpx_exc_top`

## Requirements
- R1: Each operand is split into sign bit 79, exponent bits 78:64, integer bit 63 and fraction bits 62:0, and is classified on `classA`/`classB` as follows:
  - Code 0 (zero): exponent 0, integer bit 0, fraction 0.
  - Code 2 (denormal): exponent 0 and any other content. This includes integer bit 1, the pseudo-denormal case.
  - Code 3 (infinity): exponent all ones, integer bit 1, fraction 0.
  - Code 4 (quiet NaN): exponent all ones, integer bit 1, fraction nonzero, bit 62 set.
  - Code 5 (signaling NaN): exponent all ones, integer bit 1, fraction nonzero, bit 62 clear.
  - Code 1 (normal): exponent neither 0 nor all ones, integer bit 1.
  - Code 6 (unsupported): integer bit 0 with an exponent that is not 0. This covers pseudo-NaN, pseudo-infinity, pseudo-zero and unnormal.
- R2: A signaling NaN in an active operand raises `invFlag` in both modes.
- R3: In modern mode (`legacyMode`=0), a quiet NaN raises `invFlag` only when `opClass` is 1 (compare), 2 (integer store) or 3 (decimal store). For 0 (arithmetic), 4 (transcendental), 5 (exponent extract) and 6 to 7 (treated as arithmetic), it raises nothing.
- R4: In legacy mode, a quiet NaN raises `invFlag` for every operation class.
- R5: An unsupported encoding raises `invFlag` in modern mode and raises nothing in legacy mode.
- R6: A denormal active operand raises `denFlag`, except in legacy mode with `opClass` 4 or 5.
- R7: `normReq[i]` is set for a denormal active operand i (0 = A, 1 = B) only in modern mode with `maskDen`=1. It is never set in legacy mode.
- R8: With `twoOps`=0, operand B has no effect on the flags, `normReq` or `fault`.
- R9: `fault` is high in the cycle of `valid` exactly when an unmasked flag is raised. A flag whose mask is set causes no fault.
- R10: On each clock edge, `status` (bit 0 = invalid, bit 1 = denormal) takes the OR of its old value and the flags when `valid` is high. `clear` empties it first, so `clear` together with `valid` leaves only the new flags.
- R11: While `rstN` is low, `status` is 0.
- R12: With `valid` low, `invFlag`, `denFlag`, `normReq` and `fault` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| valid | input | 1 | Operands and controls are meaningful this cycle |
| opClass | input | 3 | Operation class code |
| twoOps | input | 1 | Operand B takes part |
| operandA | input | 80 | First source operand |
| operandB | input | 80 | Second source operand |
| maskInv | input | 1 | Invalid-operation exception masked |
| maskDen | input | 1 | Denormal-operand exception masked |
| legacyMode | input | 1 | Select the older compatibility rules |
| clear | input | 1 | Empty the sticky status |
| classA | output | 3 | Class code of operand A |
| classB | output | 3 | Class code of operand B |
| invFlag | output | 1 | Invalid-operation raised this cycle |
| denFlag | output | 1 | Denormal-operand raised this cycle |
| normReq | output | 2 | Per-operand request to normalize a denormal |
| fault | output | 1 | Unmasked exception this cycle |
| status | output | 2 | Sticky exception status |

## Verification
Every output except `status` is combinational in the operands and controls. A misclassification or a wrong mode rule therefore shows on `classA`, `classB`, the flags or `fault` in the same cycle that the offending operand is presented. A fault in the sticky register shows one edge later as a missing or extra bit in `status`, and it persists until the next `clear`. The bench therefore checks the combinational outputs within the presenting cycle and checks `status` against a running model at every following cycle.

// File: rtl/fpx_exc_pkg.sv
package fpx_exc_pkg;

  parameter int unsigned EXP_W_DEF  = 15;
  parameter int unsigned FRAC_W_DEF = 63;
  parameter int unsigned NUM_OPS    = 2;
  parameter int unsigned OPC_W      = 3;

  typedef enum logic [2:0] {
    CLS_ZERO   = 3'd0,
    CLS_NORMAL = 3'd1,
    CLS_DENORM = 3'd2,
    CLS_INF    = 3'd3,
    CLS_QNAN   = 3'd4,
    CLS_SNAN   = 3'd5,
    CLS_UNSUP  = 3'd6
  } fpxCls_e;

  localparam logic [OPC_W-1:0] OPC_ARITH    = 3'd0;
  localparam logic [OPC_W-1:0] OPC_COMPARE  = 3'd1;
  localparam logic [OPC_W-1:0] OPC_INTSTORE = 3'd2;
  localparam logic [OPC_W-1:0] OPC_DECSTORE = 3'd3;
  localparam logic [OPC_W-1:0] OPC_TRANSC   = 3'd4;
  localparam logic [OPC_W-1:0] OPC_EXTRACT  = 3'd5;

  // Strobes handed from the control to the datapath.
  typedef struct packed {
    logic [NUM_OPS-1:0] invHit;
    logic [NUM_OPS-1:0] denHit;
    logic [NUM_OPS-1:0] normHit;
    logic               raiseFault;
    logic               stickyClr;
    logic               stickyLoad;
  } fpxStrobe_t;

endpackage

// File: rtl/fpx_op_class.sv
module fpx_op_class
  import fpx_exc_pkg::*;
#(
  parameter int unsigned EXP_W  = EXP_W_DEF,
  parameter int unsigned FRAC_W = FRAC_W_DEF
) (
  input  logic [EXP_W+FRAC_W:0] mag,
  output fpxCls_e               cls
);

  localparam int unsigned MAG_W = EXP_W + FRAC_W + 1;

  logic [EXP_W-1:0]  expField;
  logic              intBit;
  logic [FRAC_W-1:0] fracField;
  logic              expZero;
  logic              expOnes;
  logic              fracZero;

  assign expField  = mag[MAG_W-1:FRAC_W+1];
  assign intBit    = mag[FRAC_W];
  assign fracField = mag[FRAC_W-1:0];
  assign expZero   = (expField == '0);
  assign expOnes   = (expField == '1);
  assign fracZero  = (fracField == '0);

  always_comb begin
    if (expZero) begin
      // An explicit integer bit with zero exponent is a pseudo-denormal.
      cls = (!intBit && fracZero) ? CLS_ZERO : CLS_DENORM;
    end else if (expOnes) begin
      if (!intBit)                    cls = CLS_UNSUP;
      else if (fracZero)              cls = CLS_INF;
      else if (fracField[FRAC_W-1])   cls = CLS_QNAN;
      else                            cls = CLS_SNAN;
    end else begin
      cls = intBit ? CLS_NORMAL : CLS_UNSUP;
    end
  end

endmodule

// File: rtl/fpx_exc_ctrl.sv
module fpx_exc_ctrl
  import fpx_exc_pkg::*;
(
  input  logic                     valid,
  input  logic [OPC_W-1:0]         opClass,
  input  logic                     twoOps,
  input  logic                     legacyMode,
  input  logic                     maskInv,
  input  logic                     maskDen,
  input  logic                     clear,
  input  fpxCls_e [NUM_OPS-1:0]    cls,
  output fpxStrobe_t               strobe
);

  logic               qnanTraps;
  logic               denSkip;
  logic [NUM_OPS-1:0] invV;
  logic [NUM_OPS-1:0] denV;
  logic [NUM_OPS-1:0] normV;

  assign qnanTraps = (opClass == OPC_COMPARE) || (opClass == OPC_INTSTORE) ||
                     (opClass == OPC_DECSTORE);
  assign denSkip   = legacyMode && ((opClass == OPC_TRANSC) || (opClass == OPC_EXTRACT));

  for (genvar i = 0; i < NUM_OPS; i++) begin : g_op
    logic act;
    if (i == 0) begin : g_first
      assign act = valid;
    end else begin : g_rest
      assign act = valid & twoOps;
    end

    assign invV[i]  = act & ((cls[i] == CLS_SNAN) |
                             ((cls[i] == CLS_QNAN) & (legacyMode | qnanTraps)) |
                             ((cls[i] == CLS_UNSUP) & ~legacyMode));
    assign denV[i]  = act & (cls[i] == CLS_DENORM) & ~denSkip;
    assign normV[i] = act & (cls[i] == CLS_DENORM) & ~legacyMode & maskDen;
  end

  always_comb begin
    strobe            = '0;
    strobe.invHit     = invV;
    strobe.denHit     = denV;
    strobe.normHit    = normV;
    strobe.raiseFault = ((|invV) & ~maskInv) | ((|denV) & ~maskDen);
    strobe.stickyClr  = clear;
    strobe.stickyLoad = valid;
  end

endmodule

// File: rtl/fpx_exc_dp.sv
module fpx_exc_dp
  import fpx_exc_pkg::*;
#(
  parameter int unsigned EXP_W  = EXP_W_DEF,
  parameter int unsigned FRAC_W = FRAC_W_DEF,
  localparam int unsigned OP_W  = EXP_W + FRAC_W + 2
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic [NUM_OPS-1:0][OP_W-1:0]  operands,
  input  fpxStrobe_t                    strobe,
  output fpxCls_e [NUM_OPS-1:0]         cls,
  output logic                          invFlag,
  output logic                          denFlag,
  output logic [NUM_OPS-1:0]            normReq,
  output logic                          fault,
  output logic [1:0]                    status
);

  localparam int unsigned MAG_W = OP_W - 1;

  logic [NUM_OPS-1:0] signUnused;

  for (genvar i = 0; i < NUM_OPS; i++) begin : g_cls
    assign signUnused[i] = operands[i][OP_W-1];
    fpx_op_class #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls (
      .mag (operands[i][MAG_W-1:0]),
      .cls (cls[i])
    );
  end

  assign invFlag = |strobe.invHit;
  assign denFlag = |strobe.denHit;
  assign normReq = strobe.normHit;
  assign fault   = strobe.raiseFault;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      status <= 2'b00;
    end else if (strobe.stickyClr || strobe.stickyLoad) begin
      status <= (strobe.stickyClr ? 2'b00 : status) | {denFlag, invFlag};
    end
  end

endmodule

// File: rtl/fpx_exc_top.sv
module fpx_exc_top
  import fpx_exc_pkg::*;
#(
  parameter int unsigned EXP_W  = EXP_W_DEF,
  parameter int unsigned FRAC_W = FRAC_W_DEF,
  localparam int unsigned OP_W  = EXP_W + FRAC_W + 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              valid,
  input  logic [OPC_W-1:0]  opClass,
  input  logic              twoOps,
  input  logic [OP_W-1:0]   operandA,
  input  logic [OP_W-1:0]   operandB,
  input  logic              maskInv,
  input  logic              maskDen,
  input  logic              legacyMode,
  input  logic              clear,
  output logic [2:0]        classA,
  output logic [2:0]        classB,
  output logic              invFlag,
  output logic              denFlag,
  output logic [1:0]        normReq,
  output logic              fault,
  output logic [1:0]        status
);

  logic [NUM_OPS-1:0][OP_W-1:0] opVec;
  fpxCls_e [NUM_OPS-1:0]        clsVec;
  fpxStrobe_t                   strobe;

  assign opVec[0] = operandA;
  assign opVec[1] = operandB;

  fpx_exc_ctrl u_ctrl (
    .valid      (valid),
    .opClass    (opClass),
    .twoOps     (twoOps),
    .legacyMode (legacyMode),
    .maskInv    (maskInv),
    .maskDen    (maskDen),
    .clear      (clear),
    .cls        (clsVec),
    .strobe     (strobe)
  );

  fpx_exc_dp #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .operands (opVec),
    .strobe   (strobe),
    .cls      (clsVec),
    .invFlag  (invFlag),
    .denFlag  (denFlag),
    .normReq  (normReq),
    .fault    (fault),
    .status   (status)
  );

  assign classA = clsVec[0];
  assign classB = clsVec[1];

endmodule

// File: rtl/fpx_exc_chk.sv
module fpx_exc_chk (
  input logic       clk,
  input logic       rstN,
  input logic       valid,
  input logic       legacyMode,
  input logic       maskInv,
  input logic       maskDen,
  input logic       clear,
  input logic [2:0] classA,
  input logic       invFlag,
  input logic       denFlag,
  input logic [1:0] normReq,
  input logic       fault,
  input logic [1:0] status
);

  AST_SNAN_INVALID: assert property (@(posedge clk) disable iff (!rstN)
    (valid && classA == 3'd5) |-> invFlag); // R2

  AST_LEGACY_NO_NORM: assert property (@(posedge clk) disable iff (!rstN)
    legacyMode |-> (normReq == 2'b00)); // R7

  AST_MASKED_NO_FAULT: assert property (@(posedge clk) disable iff (!rstN)
    (maskInv && maskDen) |-> !fault); // R9

  AST_UNMASKED_FAULT: assert property (@(posedge clk) disable iff (!rstN)
    (invFlag && !maskInv) |-> fault); // R9

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !valid |-> (!invFlag && !denFlag && !fault && normReq == 2'b00)); // R12

  AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !clear |=> ((status & $past(status)) == $past(status))); // R10

  AST_STICKY_SET: assert property (@(posedge clk) disable iff (!rstN)
    (!clear && valid && invFlag) |=> status[0]); // R10

  AST_CLEAR_EMPTY: assert property (@(posedge clk) disable iff (!rstN)
    (clear && !valid) |=> (status == 2'b00)); // R10

endmodule

bind fpx_exc_top fpx_exc_chk u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .valid      (valid),
  .legacyMode (legacyMode),
  .maskInv    (maskInv),
  .maskDen    (maskDen),
  .clear      (clear),
  .classA     (classA),
  .invFlag    (invFlag),
  .denFlag    (denFlag),
  .normReq    (normReq),
  .fault      (fault),
  .status     (status)
);

// File: tb/fpx_exc_top_tb.sv
`timescale 1ns/1ps
module fpx_exc_top_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        valid = 1'b0;
  logic [2:0]  opClass = '0;
  logic        twoOps = 1'b0;
  logic [79:0] operandA = '0;
  logic [79:0] operandB = '0;
  logic        maskInv = 1'b0;
  logic        maskDen = 1'b0;
  logic        legacyMode = 1'b0;
  logic        clear = 1'b0;
  logic [2:0]  classA, classB;
  logic        invFlag, denFlag, fault;
  logic [1:0]  normReq, status;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  fpx_exc_top u_dut (
    .clk(clk), .rstN(rstN), .valid(valid), .opClass(opClass), .twoOps(twoOps),
    .operandA(operandA), .operandB(operandB), .maskInv(maskInv), .maskDen(maskDen),
    .legacyMode(legacyMode), .clear(clear), .classA(classA), .classB(classB),
    .invFlag(invFlag), .denFlag(denFlag), .normReq(normReq), .fault(fault),
    .status(status)
  );

  localparam int NPAT = 12;

  function automatic logic [79:0] pat(int k);
    case (k)
      0:  return {1'b0, 15'h0000, 1'b0, 63'h0};                    // zero
      1:  return {1'b0, 15'h3FFF, 1'b1, 63'h0};                    // normal
      2:  return {1'b0, 15'h0000, 1'b0, 63'h1};                    // denormal
      3:  return {1'b1, 15'h0000, 1'b1, 63'h5};                    // pseudo-denormal
      4:  return {1'b1, 15'h7FFF, 1'b1, 63'h0};                    // infinity
      5:  return {1'b0, 15'h7FFF, 1'b1, 63'h4000_0000_0000_0000};  // quiet NaN
      6:  return {1'b0, 15'h7FFF, 1'b1, 63'h1};                    // signaling NaN
      7:  return {1'b0, 15'h7FFF, 1'b0, 63'h4000_0000_0000_0001};  // pseudo-NaN
      8:  return {1'b1, 15'h7FFF, 1'b0, 63'h0};                    // pseudo-infinity
      9:  return {1'b0, 15'h1234, 1'b0, 63'h7};                    // unnormal
      10: return {1'b0, 15'h0100, 1'b0, 63'h0};                    // pseudo-zero
      default: return {1'b1, 15'h7FFE, 1'b1, 63'h7FFF_FFFF_FFFF_FFFF}; // max normal
    endcase
  endfunction

  function automatic logic [2:0] patCls(int k);
    case (k)
      0: return 3'd0;
      1, 11: return 3'd1;
      2, 3: return 3'd2;
      4: return 3'd3;
      5: return 3'd4;
      6: return 3'd5;
      default: return 3'd6;
    endcase
  endfunction

  function automatic bit invOf(logic [2:0] c, int opc, bit leg);
    if (c == 3'd5) return 1'b1;
    if (c == 3'd4) return leg || (opc >= 1 && opc <= 3);
    if (c == 3'd6) return !leg;
    return 1'b0;
  endfunction

  function automatic bit denOf(logic [2:0] c, int opc, bit leg);
    return (c == 3'd2) && !(leg && (opc == 4 || opc == 5));
  endfunction

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog expired actual=hung expected=done");
    finish_run();
  end

  initial begin
    logic [1:0] expStat;
    int n;
    expStat = 2'b00;
    n = 0;
    repeat (3) @(negedge clk);
    chk("R11 status in reset", {6'd0, status}, 8'd0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R11 status after reset", {6'd0, status}, 8'd0);
    chk("R12 idle fault", {7'd0, fault}, 8'd0);

    for (int leg = 0; leg < 2; leg++)
      for (int opc = 0; opc < 8; opc++)
        for (int mk = 0; mk < 4; mk++)
          for (int two = 0; two < 2; two++)
            for (int a = 0; a < NPAT; a++)
              for (int b = 0; b < NPAT; b++) begin
                logic [2:0] ca, cb;
                bit v, cl, invE, denE, faultE;
                logic [1:0] normE;
                n++;
                @(negedge clk);
                chk("R10 sticky status", {6'd0, status}, {6'd0, expStat});
                v  = (n % 7) != 3;
                cl = (n % 29) == 0;
                valid = v; clear = cl; legacyMode = leg[0]; opClass = opc[2:0];
                twoOps = two[0]; maskInv = mk[0]; maskDen = mk[1];
                operandA = pat(a); operandB = pat(b);
                #1;
                ca = patCls(a); cb = patCls(b);
                invE = v && (invOf(ca, opc, leg[0]) || (two[0] && invOf(cb, opc, leg[0])));
                denE = v && (denOf(ca, opc, leg[0]) || (two[0] && denOf(cb, opc, leg[0])));
                normE[0] = v && !leg[0] && mk[1] && ca == 3'd2;
                normE[1] = v && two[0] && !leg[0] && mk[1] && cb == 3'd2;
                faultE = (invE && !mk[0]) || (denE && !mk[1]);
                chk("R1 classA", {5'd0, classA}, {5'd0, ca});
                chk("R1 classB", {5'd0, classB}, {5'd0, cb});
                if (!v)
                  chk("R12 idle flags", {4'd0, invFlag, denFlag, normReq}, 8'd0);
                else if (!two[0])
                  chk("R8 single operand flags", {5'd0, invFlag, normReq}, {5'd0, invE, normE});
                chk("R2 R3 R4 R5 invFlag", {7'd0, invFlag}, {7'd0, invE});
                chk("R6 denFlag", {7'd0, denFlag}, {7'd0, denE});
                chk("R7 normReq", {6'd0, normReq}, {6'd0, normE});
                chk("R9 fault", {7'd0, fault}, {7'd0, faultE});
                if (cl) expStat = 2'b00;
                if (v) expStat = expStat | {denE, invE};
              end

    @(negedge clk);
    chk("R10 final status", {6'd0, status}, {6'd0, expStat});
    valid = 1'b0; clear = 1'b1;
    @(negedge clk);
    chk("R10 clear empties", {6'd0, status}, 8'd0);
    finish_run();
  end

endmodule